// File: doc/BRIEF.md
# Rotating Register Number Remapper

This decode-stage unit lets software-pipelined loops reuse one copy of the loop body instead of unrolling it. The register file has 64 architectural registers with 6-bit specifiers. The upper half of the file acts as a rotating window. A small rotation base is added to every specifier that points into that half, and the sum wraps inside the half. Specifiers for the lower half pass through unchanged. All three specifiers of an instruction (two sources and one destination) are translated combinationally in the same cycle, so the decode pipeline gains no stage.

A loop-control instruction raises the advance strobe, which moves the base forward by one. When the base rolls over from its highest value back to zero, the unit emits a one-cycle wrap pulse that a call prologue or epilogue can use to enter a spill or fill routine. A synchronous write port loads any base value, for loop setup or context restore.

Top module: `rotreg_remap`

## Requirements
- R1: A specifier with bit 5 clear (registers 0 to 31) appears unchanged on its output.
- R2: A specifier r with bit 5 set is output as 32 + ((r - 32 + base) mod 32).
- R3: Both sources and the destination are translated in the same cycle with the same base value, with no clock edge in between.
- R4: An advance strobe with no base write increments the base by one, modulo 32, at the clock edge. The instruction that presents the advance is still translated with the old base.
- R5: wrapPulse is high for exactly the one cycle after a clock edge at which an advance moved the base from 31 to 0. It is low in every other cycle.
- R6: When baseWrEn is high, the base takes baseWrData at the clock edge. This write wins over a simultaneous advance, and no wrap pulse results from that edge.
- R7: While rstN is low, the base is 0 and wrapPulse is low.
- R8: With neither advance nor a base write, the base holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Loop-control strobe; steps the base |
| baseWrEn | input | 1 | Load the base from baseWrData |
| baseWrData | input | 5 | New base value |
| srcA | input | 6 | First source specifier |
| srcB | input | 6 | Second source specifier |
| dst | input | 6 | Destination specifier |
| physA | output | 6 | Translated first source |
| physB | output | 6 | Translated second source |
| physDst | output | 6 | Translated destination |
| wrapPulse | output | 1 | One-cycle pulse after the base rolls over |

## Verification
The bench uses the default 6-bit specifier width, which gives a 5-bit base. At that size the sweep can cover every base value against every one of the 64 specifiers on all three inputs. It also drives a complete circuit of 32 advances, so the single rollover and the absence of pulses at every other step can be checked. Collisions between a base write and an advance are tried at the rollover point, where priority matters most.

// File: rtl/rotreg_pkg.sv
package rotreg_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } baseCmd_t;
endpackage

// File: rtl/rotreg_ctrl.sv
module rotreg_ctrl
  import rotreg_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     advance,
  input  logic     baseWrEn,
  input  logic     stepCarry,
  output baseCmd_t cmd,
  output logic     wrapPulse
);
  // a base write wins over an advance in the same cycle
  always_comb begin
    cmd.load = baseWrEn;
    cmd.step = advance & ~baseWrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrapPulse <= 1'b0;
    else       wrapPulse <= cmd.step & stepCarry;
  end

  // R5: a pulse can only follow an accepted advance
  a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |-> $past(advance && !baseWrEn));
  // R5: never two pulses in a row
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> !wrapPulse);
  // R6: a write edge never produces a pulse
  a_r6_no_wrap_on_load: assert property (@(posedge clk) disable iff (!rstN)
    baseWrEn |=> !wrapPulse);
endmodule

// File: rtl/rotreg_datapath.sv
module rotreg_datapath
  import rotreg_pkg::*;
#(
  parameter int SPEC_W   = 6,
  parameter int NUM_SPEC = 3,
  localparam int BASE_W  = SPEC_W - 1,
  localparam int BUS_W   = SPEC_W * NUM_SPEC
) (
  input  logic              clk,
  input  logic              rstN,
  input  baseCmd_t          cmd,
  input  logic [BASE_W-1:0] wrData,
  input  logic [BUS_W-1:0]  specIn,
  output logic [BUS_W-1:0]  specOut,
  output logic              stepCarry
);
  logic [BASE_W-1:0] baseQ;
  logic [BASE_W-1:0] baseInc;

  assign {stepCarry, baseInc} = {1'b0, baseQ} + {{BASE_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN)         baseQ <= '0;
    else if (cmd.load) baseQ <= wrData;
    else if (cmd.step) baseQ <= baseInc;
  end

  for (genvar i = 0; i < NUM_SPEC; i++) begin : g_spec
    logic [SPEC_W-1:0] specRaw;
    logic [BASE_W-1:0] slotSum;
    assign specRaw = specIn[i*SPEC_W +: SPEC_W];
    assign slotSum = specRaw[BASE_W-1:0] + baseQ;
    assign specOut[i*SPEC_W +: SPEC_W] =
      specRaw[SPEC_W-1] ? {1'b1, slotSum} : specRaw;
  end

  // R4: an accepted step moves the base by one
  a_r4_step_increments: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.load) |=> baseQ == $past(baseQ) + 1'b1);
  // R6: a load takes the written value
  a_r6_load_value: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> baseQ == $past(wrData));
  // R8: idle cycles keep the base
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.step) |=> $stable(baseQ));
endmodule

// File: rtl/rotreg_remap.sv
module rotreg_remap
  import rotreg_pkg::*;
#(
  parameter int SPEC_W  = 6,
  localparam int BASE_W = SPEC_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              baseWrEn,
  input  logic [BASE_W-1:0] baseWrData,
  input  logic [SPEC_W-1:0] srcA,
  input  logic [SPEC_W-1:0] srcB,
  input  logic [SPEC_W-1:0] dst,
  output logic [SPEC_W-1:0] physA,
  output logic [SPEC_W-1:0] physB,
  output logic [SPEC_W-1:0] physDst,
  output logic              wrapPulse
);
  baseCmd_t            cmd;
  logic                stepCarry;
  logic [3*SPEC_W-1:0] specBus;
  logic [3*SPEC_W-1:0] physBus;

  assign specBus = {dst, srcB, srcA};
  assign {physDst, physB, physA} = physBus;

  rotreg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .advance   (advance),
    .baseWrEn  (baseWrEn),
    .stepCarry (stepCarry),
    .cmd       (cmd),
    .wrapPulse (wrapPulse)
  );

  rotreg_datapath #(.SPEC_W(SPEC_W), .NUM_SPEC(3)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .wrData    (baseWrData),
    .specIn    (specBus),
    .specOut   (physBus),
    .stepCarry (stepCarry)
  );

  // R1: lower-half specifiers are never touched
  a_r1_low_passthru: assert property (@(posedge clk) disable iff (!rstN)
    !srcA[SPEC_W-1] |-> physA == srcA);
  // R3: sources and destination share one base
  a_r3_same_base: assert property (@(posedge clk) disable iff (!rstN)
    (srcA == dst) |-> physA == physDst);
endmodule

// File: tb/rotreg_remap_bench.sv
module rotreg_remap_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       advance = 1'b0;
  logic       baseWrEn = 1'b0;
  logic [4:0] baseWrData = '0;
  logic [5:0] srcA = '0, srcB = '0, dst = '0;
  logic [5:0] physA, physB, physDst;
  logic       wrapPulse;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rotreg_remap u_rotreg_remap (
    .clk(clk), .rstN(rstN), .advance(advance), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .srcA(srcA), .srcB(srcB), .dst(dst),
    .physA(physA), .physB(physB), .physDst(physDst), .wrapPulse(wrapPulse)
  );

  function automatic logic [5:0] expMap(input int r, input int b);
    if (r < 32) return r[5:0];
    return 6'(32 + ((r - 32 + b) % 32));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sample the three outputs for one specifier triple
  task automatic probe(input string req, input int a, input int b, input int d, input int base);
    srcA = 6'(a); srcB = 6'(b); dst = 6'(d);
    #1;
    chk(req, physA, expMap(a, base));
    chk(req, physB, expMap(b, base));
    chk(req, physDst, expMap(d, base));
  endtask

  // one clock with the given strobes, ending at the next negedge
  task automatic tick(input logic adv, input logic we, input int wd);
    advance = adv; baseWrEn = we; baseWrData = 5'(wd);
    @(negedge clk);
    advance = 1'b0; baseWrEn = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset state
    @(negedge clk); @(negedge clk);
    chk("R7 wrap in reset", wrapPulse, 0);
    probe("R7 base zero in reset", 40, 63, 32, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R3: every base against every specifier, loaded via R6
    for (int b = 0; b < 32; b++) begin
      tick(1'b0, 1'b1, b);
      chk("R6 no wrap after load", wrapPulse, 0);
      for (int r = 0; r < 64; r++)
        probe(r < 32 ? "R1 passthru" : "R2 R3 remap", r, 63 - r, (r + 17) % 64, b);
    end

    // R8: idle holds base (31 loaded last)
    tick(1'b0, 1'b0, 0);
    tick(1'b0, 1'b0, 0);
    probe("R8 hold", 32, 33, 5, 31);

    // R4 R5: full circuit of advances from 0
    tick(1'b0, 1'b1, 0);
    for (int s = 1; s <= 33; s++) begin
      srcA = 6'd32;
      #1 chk("R4 old base during advance", physA, expMap(32, (s - 1) % 32));
      tick(1'b1, 1'b0, 0);
      chk("R5 wrap pulse", wrapPulse, (s == 32) ? 1 : 0);
      probe("R4 stepped base", 32, 45, 63, s % 32);
      tick(1'b0, 1'b0, 0);
      chk("R5 one cycle only", wrapPulse, 0);
    end

    // R6: write beats advance at the rollover point
    tick(1'b0, 1'b1, 31);
    tick(1'b1, 1'b1, 9);
    chk("R6 no wrap on collision", wrapPulse, 0);
    probe("R6 written base wins", 32, 50, 7, 9);

    // R5: rollover after a loaded 31 pulses once
    tick(1'b0, 1'b1, 31);
    tick(1'b1, 1'b0, 0);
    chk("R5 wrap from loaded 31", wrapPulse, 1);
    probe("R4 wrapped to zero", 32, 63, 40, 0);
    tick(1'b1, 1'b0, 0);
    chk("R5 no wrap at 0 to 1", wrapPulse, 0);

    // R7: reset clears a nonzero base
    tick(1'b0, 1'b1, 20);
    rstN = 1'b0;
    @(negedge clk);
    probe("R7 reset clears base", 33, 60, 2, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule